// File: doc/BRIEF.md
# Synchronous Burst SRAM with Interleaved Line Fill

This block is a clocked static memory with its own burst address sequencer. It is meant to model the secondary cache memory behind a processor whose primary cache refills one line of four words at a time. The requester presents one start address together with a strobe. The block then sequences through the four words of the aligned block containing that address, with no further addresses supplied. Each step is gated by an advance input. Reads and writes both use this sequencing. The kind of burst is chosen by the write-enable level at the strobe.

The word order is the interleaved one: the word offset is the low start-address bits XORed with a running count. The burst therefore always stays inside its aligned block, and the order depends on where it starts. A build-time mode selects the output timing. Flow-through mode sends the array output straight to the pins, giving 2-1-1-1 read timing. Pipelined mode puts a register between the array and the pins, which costs one cycle on the first word and gives 3-1-1-1 timing. The default geometry is a small array of 1024 words of 32 bits. Setting the address width to 15 gives the full 32K-word organisation.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after that edge, `rd_valid` is 0. Any burst in progress is dropped.
- R2: Flow-through mode (`OUT_MODE` = OUT_FLOW, encoding 0). If `burst_start` is high at edge N, the first read word is on `rd_data` with `rd_valid`=1 during the cycle after edge N. With `burst_adv` held high, each following word appears one cycle later (2-1-1-1).
- R3: Pipelined mode (`OUT_MODE` = OUT_PIPE, encoding 1). `rd_data` and `rd_valid` are the flow-through values delayed by exactly one clock, so the first word appears one cycle later (3-1-1-1).
- R4: Word k of a burst (k = 0..3) comes from address {start[ADDR_W-1:2], start[1:0] XOR k}. The upper address bits never change within a burst, so the burst wraps inside the aligned four-word block.
- R5: A cycle with `burst_adv` low and `burst_start` low keeps the current word and the valid state unchanged.
- R6: The edge at which `burst_adv` is high on the fourth word ends the burst. After that, `rd_valid` falls (one cycle later in pipelined mode), and further advances have no effect.
- R7: `burst_start` during a burst aborts it and starts a new burst from the new address with the same timing as in R2/R3. The strobe takes priority over `burst_adv` in the same cycle.
- R8: A burst started with `wr_en`=1 is a write burst. On each edge with `burst_adv` high, `wr_data` is stored at the current interleaved address. Data presented with `burst_adv` low is not stored. `rd_valid` stays 0 for the whole write burst.
- R9: `rd_valid` is 1 exactly in cycles where the pins carry read-burst data. Advances or write enables without an active burst leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Address strobe: begin a burst at `burst_addr` |
| burst_addr | input | ADDR_W | Start address, sampled with the strobe |
| burst_adv | input | 1 | Step the burst counter (and write, in a write burst) |
| wr_en | input | 1 | Sampled with the strobe: 1 selects a write burst |
| wr_data | input | DATA_W | Write data, stored on advancing edges of a write burst |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | High when `rd_data` carries read-burst data |

## Verification
The hardest case to reach is an abort in pipelined mode. When a new strobe arrives mid-burst, the output register still holds a word of the old burst for one cycle, and the new burst's first word must follow directly behind it. The bench reaches this by driving one input sequence into a flow-through instance and a pipelined instance at the same time, and striking a strobe in the middle of an advancing burst. Stalled advances at every word position come from a table of advance patterns. Write bursts with a stalled cycle carrying junk data leave traces that the later interleaved reads expose.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Output timing variant of the memory.
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

    // Per-burst control flags.
    typedef struct packed {
        logic active;
        logic is_write;
    } burst_flags_t;

    // Interleaved slot: start offset XOR running count.
    function automatic logic [7:0] burst_slot(input logic [7:0] start_ofs,
                                              input logic [7:0] count);
        return start_ofs ^ count;
    endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    input  logic              we_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              rd_active_o,
    output logic              wr_fire_o
);
    import sbs_pkg::*;

    localparam int unsigned OFS_W = $clog2(BURST_LEN);
    localparam int unsigned HI_W  = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] LAST_CNT = OFS_W'(BURST_LEN - 1);

    burst_flags_t     flags_q;
    logic [HI_W-1:0]  base_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] cnt_q;
    logic             last_w;

    assign last_w      = (cnt_q == LAST_CNT);
    assign cur_addr_o  = {base_q, OFS_W'(burst_slot(8'(ofs_q), 8'(cnt_q)))};
    assign rd_active_o = flags_q.active && !flags_q.is_write;
    assign wr_fire_o   = flags_q.active && flags_q.is_write && adv_i && !start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            base_q  <= '0;
            ofs_q   <= '0;
            cnt_q   <= '0;
        end else if (start_i) begin
            flags_q.active   <= 1'b1;
            flags_q.is_write <= we_i;
            base_q           <= addr_i[ADDR_W-1:OFS_W];
            ofs_q            <= addr_i[OFS_W-1:0];
            cnt_q            <= '0;
        end else if (flags_q.active && adv_i) begin
            if (last_w) begin
                flags_q.active <= 1'b0;
            end else begin
                cnt_q <= cnt_q + OFS_W'(1);
            end
        end
    end

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (flags_q.active && cnt_q == '0 && cur_addr_o == $past(addr_i)));

    // R4
    block_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.active && !start_i) |=>
            (cur_addr_o[ADDR_W-1:OFS_W] == $past(cur_addr_o[ADDR_W-1:OFS_W])));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.active && !start_i && !adv_i) |=> ($stable(cur_addr_o) && flags_q.active));

    // R6
    burst_end_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.active && last_w && adv_i && !start_i) |=> !flags_q.active);

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i) begin
            cells_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[addr_i];

    // R8
    wr_known_chk: assert property (@(posedge clk)
        wr_i |-> !$isunknown({addr_i, wdata_i}));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int unsigned        ADDR_W    = 10,
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        BURST_LEN = 4,
    parameter sbs_pkg::out_mode_e OUT_MODE  = sbs_pkg::OUT_FLOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              burst_adv,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] cur_addr;
    logic              rd_active;
    logic              wr_fire;
    logic [DATA_W-1:0] arr_rdata;

    sbs_burst_ctrl #(
        .ADDR_W   (ADDR_W),
        .BURST_LEN(BURST_LEN)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (burst_start),
        .addr_i     (burst_addr),
        .adv_i      (burst_adv),
        .we_i       (wr_en),
        .cur_addr_o (cur_addr),
        .rd_active_o(rd_active),
        .wr_fire_o  (wr_fire)
    );

    sbs_mem_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_mem (
        .clk    (clk),
        .addr_i (cur_addr),
        .wr_i   (wr_fire),
        .wdata_i(wr_data),
        .rdata_o(arr_rdata)
    );

    generate
        if (OUT_MODE == sbs_pkg::OUT_PIPE) begin : g_pipe
            logic [DATA_W-1:0] data_q;
            logic              valid_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q  <= '0;
                    valid_q <= 1'b0;
                end else begin
                    data_q  <= arr_rdata;
                    valid_q <= rd_active;
                end
            end

            assign rd_data  = data_q;
            assign rd_valid = valid_q;

            // R3
            pipe_lag_chk: assert property (@(posedge clk) disable iff (rst)
                rd_active |=> rd_valid);
        end else begin : g_flow
            assign rd_data  = arr_rdata;
            assign rd_valid = rd_active;
        end
    endgenerate

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          s_start;
    logic [AW-1:0] s_addr;
    logic          s_adv;
    logic          s_we;
    logic [DW-1:0] s_wdata;
    logic [DW-1:0] f_data, p_data;
    logic          f_valid, p_valid;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .OUT_MODE(sbs_pkg::OUT_FLOW)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .burst_start(s_start), .burst_addr(s_addr),
        .burst_adv(s_adv), .wr_en(s_we), .wr_data(s_wdata),
        .rd_data(f_data), .rd_valid(f_valid));

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .OUT_MODE(sbs_pkg::OUT_PIPE)) i_sync_burst_sram_pipe (
        .clk(clk), .rst(rst), .burst_start(s_start), .burst_addr(s_addr),
        .burst_adv(s_adv), .wr_en(s_we), .wr_data(s_wdata),
        .rd_data(p_data), .rd_valid(p_valid));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [DW-1:0] bmem [1 << AW];
    logic          m_act, m_wr;
    logic [AW-1:0] m_start;
    int            m_cnt;
    logic          m_fvalid, m_pvalid;
    logic [DW-1:0] m_fdata, m_pdata;

    // {start address, advance pattern (bit k = cycle k after strobe)}
    localparam logic [17:0] VEC [8] = '{
        {10'h040, 8'b0000_1111},
        {10'h041, 8'b0000_1111},
        {10'h042, 8'b0000_1111},
        {10'h043, 8'b0000_1111},
        {10'h3FD, 8'b0001_1011},
        {10'h3FE, 8'b1010_1010},
        {10'h126, 8'b0000_1111},
        {10'h127, 8'b0110_0011}
    };

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a, 6'h2B, a, 6'h19};
    endfunction

    function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] st, input int k);
        return {st[AW-1:2], st[1:0] ^ 2'(k)};
    endfunction

    task automatic model_clear();
        m_act = 1'b0; m_wr = 1'b0; m_cnt = 0; m_start = '0;
        m_fvalid = 1'b0; m_pvalid = 1'b0; m_fdata = '0; m_pdata = '0;
    endtask

    task automatic compare(input string tag);
        n_tests++;
        if (f_valid !== m_fvalid || (m_fvalid && f_data !== m_fdata)) begin
            n_fail++;
            $display("FAIL %s flow: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, f_valid, f_data, m_fvalid, m_fdata);
        end
        n_tests++;
        if (p_valid !== m_pvalid || (m_pvalid && p_data !== m_pdata)) begin
            n_fail++;
            $display("FAIL R3/%s pipe: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, p_valid, p_data, m_pvalid, m_pdata);
        end
    endtask

    // Called at a falling edge: check outputs, drive inputs, advance model, wait.
    task automatic step(input logic st, input logic [AW-1:0] a, input logic adv,
                        input logic we, input logic [DW-1:0] d, input string tag);
        compare(tag);
        s_start = st; s_addr = a; s_adv = adv; s_we = we; s_wdata = d;
        m_pvalid = m_fvalid;
        m_pdata  = m_fdata;
        if (st) begin
            m_act = 1'b1; m_wr = we; m_start = a; m_cnt = 0;
        end else if (m_act && adv) begin
            if (m_wr) bmem[slot_addr(m_start, m_cnt)] = d;
            if (m_cnt == 3) m_act = 1'b0;
            else m_cnt++;
        end
        m_fvalid = m_act && !m_wr;
        m_fdata  = m_fvalid ? bmem[slot_addr(m_start, m_cnt)] : '0;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, '0, tag);
    endtask

    // R8: write burst with a stalled cycle carrying junk data.
    task automatic write_block(input logic [AW-1:0] st);
        step(1'b1, st, 1'b0, 1'b1, 32'h0BAD_0BAD, "R8");
        for (int k = 0; k < 4; k++) begin
            if (k == 2) step(1'b0, '0, 1'b0, 1'b0, 32'hDEAD_BEEF, "R8");
            step(1'b0, '0, 1'b1, 1'b0, pat(slot_addr(st, k)), "R8");
        end
        idle(2, "R8");
    endtask

    initial begin
        rst = 1'b1; s_start = 1'b0; s_addr = '0; s_adv = 1'b0; s_we = 1'b0; s_wdata = '0;
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        compare("R1");
        rst = 1'b0;
        @(negedge clk);

        // R9: advances and write enables with no burst leave valid low
        step(1'b0, '0, 1'b1, 1'b1, 32'h1234_5678, "R9");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R9");
        idle(1, "R9");

        write_block(10'h042);
        write_block(10'h3FF);
        write_block(10'h125);

        // R2: plain read burst with 2-1-1-1 timing
        step(1'b1, 10'h040, 1'b0, 1'b0, '0, "R2");
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 1'b0, '0, "R2");
        // R6: burst over, advances ignored
        step(1'b0, '0, 1'b1, 1'b0, '0, "R6");
        idle(2, "R6");

        // R4: table of start offsets and advance patterns
        for (int v = 0; v < 8; v++) begin
            step(1'b1, VEC[v][17:8], 1'b0, 1'b0, '0, "R4");
            for (int c = 0; c < 8; c++) step(1'b0, '0, VEC[v][c], 1'b0, '0, "R4");
            idle(2, "R4");
        end

        // R5: long stall on the second word
        step(1'b1, 10'h3FC, 1'b1, 1'b0, '0, "R5");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, 1'b0, '0, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, '0, "R5");
        idle(2, "R5");

        // R7: abort mid-burst, strobe together with advance
        step(1'b1, 10'h041, 1'b0, 1'b0, '0, "R7");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R7");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R7");
        step(1'b1, 10'h126, 1'b1, 1'b0, '0, "R7");
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 1'b0, '0, "R7");
        idle(2, "R7");

        // R7: read burst aborted by a write burst, then read back
        step(1'b1, 10'h127, 1'b1, 1'b0, '0, "R7");
        step(1'b1, 10'h124, 1'b0, 1'b1, '0, "R7");
        for (int k = 0; k < 4; k++)
            step(1'b0, '0, 1'b1, 1'b0, ~pat(slot_addr(10'h124, k)), "R8");
        step(1'b1, 10'h125, 1'b0, 1'b0, '0, "R8");
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 1'b0, '0, "R8");
        idle(2, "R8");

        // R1: reset in the middle of a burst
        step(1'b1, 10'h042, 1'b1, 1'b0, '0, "R1");
        step(1'b0, '0, 1'b1, 1'b0, '0, "R1");
        compare("R1");
        rst = 1'b1;
        s_adv = 1'b0;
        @(negedge clk);
        model_clear();
        compare("R1");
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        @(negedge clk);
        idle(2, "R1");

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule